// File: doc/BRIEF.md
# Four-Phase Accumulator Processor Core

This block is a small accumulator processor core. Each instruction takes four clock cycles, called phases Q1 to Q4, which a two-bit phase counter generates from the input clock. In Q1 the core reads a 12-bit instruction word from an external program memory into its instruction register. In Q2 it splits that word into a 4-bit opcode and an 8-bit operand. In Q3 the ALU takes the operand, or a byte read from the data RAM at the operand address, and combines it with the working register W. In Q4 the core writes the result into W, or writes W to the data RAM for a store, and advances the program counter.

Both memories sit outside the core. The program memory is read combinationally from the program address output. The data RAM has a combinational read port and a write port that is clocked at the end of Q4. W, a zero flag and the current phase are visible at the ports, so the surrounding logic can watch execution phase by phase. Interrupts, I/O ports and pipelining are not part of this block.

Top module: `quadphase_core`

## Requirements
- R1: `phase` steps through 0, 1, 2, 3 and back to 0 on every clock, where 0..3 encode Q1..Q4. It is 0 while reset is held.
- R2: The instruction word is 12 bits, with the opcode in bits [11:8] and the operand in bits [7:0]. `progAddr` is the program counter. It changes only at the end of Q4, where it steps up by one and wraps modulo 2^PC_W. Reset sets it to 0.
- R3: W (`wReg`) and `zeroFlag` change only on the clock edge that ends Q4. Reset sets W to 0 and `zeroFlag` to 1.
- R4: Opcode 1 (load literal) sets W to the operand.
- R5: Opcode 2 (add literal) sets W to (W + operand) mod 256.
- R6: Opcode 3 (AND literal) sets W to W bitwise-AND the operand.
- R7: Opcode 4 (load from RAM) sets W to the RAM byte at the operand address. `ramAddr` carries that address, and `ramRdata` is sampled at the end of Q3.
- R8: Opcode 5 (add from RAM) sets W to (W + RAM[operand]) mod 256.
- R9: Opcode 6 (store) drives `ramWe` high during Q4 only, with `ramAddr` equal to the operand and `ramWdata` equal to W. W and `zeroFlag` do not change. `ramWe` is never high outside Q4 or for any other opcode.
- R10: Opcode 0 (no-op) and the unused opcodes 7..15 change neither W nor `zeroFlag`, and they write no RAM.
- R11: Each time W is written, `zeroFlag` becomes 1 if the new W is zero and 0 otherwise, so `zeroFlag` always equals (W == 0).
- R12: Reset is asynchronous and active low. Pulling `rstN` low at any phase at once returns phase, program counter, W and `zeroFlag` to their reset values. Once `rstN` is released, execution restarts at address 0 with a fresh Q1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; one instruction takes four cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| progAddr | output | PC_W | Program memory address (program counter) |
| progData | input | 4+DATA_W | Instruction word from program memory |
| ramAddr | output | DATA_W | Data RAM address (the operand field) |
| ramWdata | output | DATA_W | Data RAM write data (W) |
| ramWe | output | 1 | Data RAM write enable, high in Q4 of a store |
| ramRdata | input | DATA_W | Data RAM combinational read data |
| wReg | output | DATA_W | Working register W |
| zeroFlag | output | 1 | Set when the last value written to W was zero |
| phase | output | 2 | Current phase, 0..3 for Q1..Q4 |

## Verification
Once reset is released, W, the zero flag and the program address are due exactly four clock edges after the Q1 that fetches their instruction. The bench waits four rising edges for each instruction and samples at the falling edge that follows, when `phase` must read 0 again and every port must match a reference model stepped once per instruction. A RAM write lands on the fourth of those edges, so the bench checks the RAM image it owns at that same falling edge. A per-cycle monitor, also sampling on falling edges, checks that the phase advances by one each clock, that W and the flag do not move in any phase other than Q1, and that `ramWe` is high only in Q4. The asynchronous reset check samples a fraction of a nanosecond after `rstN` falls in the middle of Q3.

// File: rtl/qp_pkg.sv
package qp_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_NOP  = 4'h0;
  localparam logic [OPC_W-1:0] OPC_LDL  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_ADDL = 4'h2;
  localparam logic [OPC_W-1:0] OPC_ANDL = 4'h3;
  localparam logic [OPC_W-1:0] OPC_LDR  = 4'h4;
  localparam logic [OPC_W-1:0] OPC_ADDR = 4'h5;
  localparam logic [OPC_W-1:0] OPC_STR  = 4'h6;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phaseE;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_AND  = 2'd2
  } aluOpE;

  // Strobes from control to datapath
  typedef struct packed {
    logic  irLoad;     // capture instruction word (end of Q1)
    logic  splitLoad;  // split into opcode / operand (end of Q2)
    logic  execLoad;   // register ALU result (end of Q3)
    logic  srcRam;     // ALU source is RAM data instead of operand
    aluOpE aluOp;
    logic  wWrite;     // update W and zero flag (end of Q4)
    logic  ramWrite;   // store W to RAM (Q4)
    logic  pcStep;     // advance program counter (end of Q4)
  } ctrlS;

endpackage

// File: rtl/qp_alu.sv
module qp_alu
  import qp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluOpE             opSel,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] accVal,
  output logic [DATA_W-1:0] result
);

  always_comb begin
    unique case (opSel)
      ALU_ADD: result = srcVal + accVal;
      ALU_AND: result = srcVal & accVal;
      default: result = srcVal;
    endcase
  end

endmodule

// File: rtl/qp_ctrl.sv
module qp_ctrl
  import qp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPC_W-1:0] opcode,
  output phaseE            phase,
  output ctrlS             ctrl
);

  logic  writesW;
  logic  isStore;
  logic  srcRam;
  aluOpE aluOp;

  // Phase generator: Q1 -> Q2 -> Q3 -> Q4 -> Q1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_Q1;
    else       phase <= phaseE'(phase + 2'd1);
  end

  // Instruction decoder
  always_comb begin
    writesW = 1'b0;
    isStore = 1'b0;
    srcRam  = 1'b0;
    aluOp   = ALU_PASS;
    unique case (opcode)
      OPC_LDL:  writesW = 1'b1;
      OPC_ADDL: begin writesW = 1'b1; aluOp = ALU_ADD; end
      OPC_ANDL: begin writesW = 1'b1; aluOp = ALU_AND; end
      OPC_LDR:  begin writesW = 1'b1; srcRam = 1'b1; end
      OPC_ADDR: begin writesW = 1'b1; srcRam = 1'b1; aluOp = ALU_ADD; end
      OPC_STR:  isStore = 1'b1;
      default:  ;
    endcase
  end

  always_comb begin
    ctrl.irLoad    = (phase == PH_Q1);
    ctrl.splitLoad = (phase == PH_Q2);
    ctrl.execLoad  = (phase == PH_Q3);
    ctrl.srcRam    = srcRam;
    ctrl.aluOp     = aluOp;
    ctrl.wWrite    = (phase == PH_Q4) && writesW;
    ctrl.ramWrite  = (phase == PH_Q4) && isStore;
    ctrl.pcStep    = (phase == PH_Q4);
  end

endmodule

// File: rtl/qp_datapath.sv
module qp_datapath
  import qp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlS                    ctrl,
  input  logic [OPC_W+DATA_W-1:0] progData,
  input  logic [DATA_W-1:0]       ramRdata,
  output logic [PC_W-1:0]         progAddr,
  output logic [OPC_W-1:0]        opcode,
  output logic [DATA_W-1:0]       ramAddr,
  output logic [DATA_W-1:0]       ramWdata,
  output logic                    ramWe,
  output logic [DATA_W-1:0]       wReg,
  output logic                    zeroFlag
);

  localparam int INSTR_W = OPC_W + DATA_W;

  logic [PC_W-1:0]    pc;
  logic [INSTR_W-1:0] ir;
  logic [OPC_W-1:0]   opReg;
  logic [DATA_W-1:0]  argReg;
  logic [DATA_W-1:0]  resReg;
  logic [DATA_W-1:0]  aluSrc;
  logic [DATA_W-1:0]  aluOut;

  // Program counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pc <= '0;
    else if (ctrl.pcStep) pc <= pc + 1'b1;
  end

  // Instruction register (Q1) and opcode/operand split (Q2)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ir     <= '0;
      opReg  <= OPC_NOP;
      argReg <= '0;
    end else begin
      if (ctrl.irLoad) ir <= progData;
      if (ctrl.splitLoad) begin
        opReg  <= ir[INSTR_W-1:DATA_W];
        argReg <= ir[DATA_W-1:0];
      end
    end
  end

  // ALU operate (Q3)
  assign aluSrc = ctrl.srcRam ? ramRdata : argReg;

  qp_alu #(.DATA_W(DATA_W)) uAlu (
    .opSel  (ctrl.aluOp),
    .srcVal (aluSrc),
    .accVal (wReg),
    .result (aluOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              resReg <= '0;
    else if (ctrl.execLoad) resReg <= aluOut;
  end

  // Write-back (Q4)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wReg     <= '0;
      zeroFlag <= 1'b1;
    end else if (ctrl.wWrite) begin
      wReg     <= resReg;
      zeroFlag <= (resReg == '0);
    end
  end

  assign progAddr = pc;
  assign opcode   = opReg;
  assign ramAddr  = argReg;
  assign ramWdata = wReg;
  assign ramWe    = ctrl.ramWrite;

endmodule

// File: rtl/quadphase_core.sv
module quadphase_core
  import qp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  output logic [PC_W-1:0]         progAddr,
  input  logic [OPC_W+DATA_W-1:0] progData,
  output logic [DATA_W-1:0]       ramAddr,
  output logic [DATA_W-1:0]       ramWdata,
  output logic                    ramWe,
  input  logic [DATA_W-1:0]       ramRdata,
  output logic [DATA_W-1:0]       wReg,
  output logic                    zeroFlag,
  output logic [1:0]              phase
);

  ctrlS             ctrl;
  phaseE            phaseQ;
  logic [OPC_W-1:0] opcode;

  qp_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .opcode (opcode),
    .phase  (phaseQ),
    .ctrl   (ctrl)
  );

  qp_datapath #(.DATA_W(DATA_W), .PC_W(PC_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .progData (progData),
    .ramRdata (ramRdata),
    .progAddr (progAddr),
    .opcode   (opcode),
    .ramAddr  (ramAddr),
    .ramWdata (ramWdata),
    .ramWe    (ramWe),
    .wReg     (wReg),
    .zeroFlag (zeroFlag)
  );

  assign phase = phaseQ;

endmodule

// File: rtl/qp_checker.sv
module qp_checker #(
  parameter int DATA_W = 8,
  parameter int PC_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        phase,
  input logic [PC_W-1:0]   progAddr,
  input logic [DATA_W-1:0] wReg,
  input logic              zeroFlag,
  input logic              ramWe
);

  assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (phase == 2'($past(phase) + 2'd1)));

  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase != 2'd0) |-> $stable(progAddr));

  assert_w_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase != 2'd0) |-> ($stable(wReg) && $stable(zeroFlag)));

  assert_store_q4_R9: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (phase == 2'd3));

  assert_zero_track_R11: assert property (@(posedge clk) disable iff (!rstN)
    zeroFlag == (wReg == '0));

endmodule

bind quadphase_core qp_checker #(.DATA_W(DATA_W), .PC_W(PC_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .phase    (phase),
  .progAddr (progAddr),
  .wReg     (wReg),
  .zeroFlag (zeroFlag),
  .ramWe    (ramWe)
);

// File: tb/sim_quadphase_core.sv
`timescale 1ns/100ps
module sim_quadphase_core;

  localparam int DATA_W = 8;
  localparam int PC_W   = 8;
  localparam int INSTR_W = 4 + DATA_W;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [PC_W-1:0]     progAddr;
  logic [INSTR_W-1:0]  progData;
  logic [DATA_W-1:0]   ramAddr, ramWdata, ramRdata, wReg;
  logic                ramWe, zeroFlag;
  logic [1:0]          phase;

  logic [INSTR_W-1:0]  rom  [256];
  logic [DATA_W-1:0]   ram  [256];
  logic [DATA_W-1:0]   mRam [256];

  logic [DATA_W-1:0]   mW;
  logic                mZ;
  logic [PC_W-1:0]     mPc;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  bit  monValid = 1'b0;
  logic [DATA_W-1:0] prevW;
  logic              prevZ;
  logic [1:0]        prevPhase;

  always #2.5 clk = ~clk;

  quadphase_core #(.DATA_W(DATA_W), .PC_W(PC_W)) u0 (
    .clk(clk), .rstN(rstN), .progAddr(progAddr), .progData(progData),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .ramWe(ramWe), .ramRdata(ramRdata),
    .wReg(wReg), .zeroFlag(zeroFlag), .phase(phase)
  );

  assign progData = rom[progAddr];
  assign ramRdata = ram[ramAddr];

  always @(posedge clk) if (ramWe) ram[ramAddr] <= ramWdata;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      4'h1: return "R4";
      4'h2: return "R5";
      4'h3: return "R6";
      4'h4: return "R7";
      4'h5: return "R8";
      4'h6: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [INSTR_W-1:0] mk(input logic [3:0] op, input logic [7:0] k);
    return {op, k};
  endfunction

  // Per-cycle monitor at falling edges
  always @(negedge clk) begin
    if (!rstN) begin
      monValid = 1'b0;
    end else begin
      if (monValid) begin
        check(phase == 2'(prevPhase + 2'd1), "R1", "phase step", phase, 2'(prevPhase + 2'd1));
        if (phase != 2'd0)
          check(wReg == prevW && zeroFlag == prevZ, "R3", "W/Z moved mid-instruction",
                {wReg, zeroFlag}, {prevW, prevZ});
      end
      check(!ramWe || phase == 2'd3, "R9", "ramWe outside Q4", phase, 3);
      prevW = wReg; prevZ = zeroFlag; prevPhase = phase;
      monValid = 1'b1;
    end
  end

  task automatic runInstr();
    logic [INSTR_W-1:0] ins;
    logic [3:0] op;
    logic [7:0] k;
    string tag;
    ins = rom[mPc];
    op = ins[11:8];
    k = ins[7:0];
    tag = tagOf(op);
    case (op)
      4'h1: mW = k;
      4'h2: mW = mW + k;
      4'h3: mW = mW & k;
      4'h4: mW = mRam[k];
      4'h5: mW = mW + mRam[k];
      4'h6: mRam[k] = mW;
      default: ;
    endcase
    if (op >= 4'h1 && op <= 4'h5) mZ = (mW == 8'h00);
    mPc = mPc + 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(wReg == mW, tag, "W after instruction", wReg, mW);
    check(zeroFlag == mZ, (op >= 4'h1 && op <= 4'h5) ? "R11" : tag, "zero flag", zeroFlag, mZ);
    check(phase == 2'd0, "R1", "phase at instruction boundary", phase, 0);
    check(progAddr == mPc, "R2", "program address", progAddr, mPc);
    if (op == 4'h6) check(ram[k] == mRam[k], "R9", "stored byte", ram[k], mRam[k]);
  endtask

  initial begin
    int unusedSeed;
    unusedSeed = $urandom(32'h00C0FFEE);
    for (int i = 0; i < 256; i++) begin
      ram[i]  = 8'($urandom_range(0, 255));
      mRam[i] = ram[i];
    end
    // Directed corner cases
    rom[0]  = mk(4'h1, 8'hFF);  // LDL FF
    rom[1]  = mk(4'h2, 8'h01);  // ADDL wrap to zero
    rom[2]  = mk(4'h1, 8'h3C);
    rom[3]  = mk(4'h3, 8'hC3);  // AND to zero
    rom[4]  = mk(4'h1, 8'h5A);
    rom[5]  = mk(4'h6, 8'h07);  // store
    rom[6]  = mk(4'h0, 8'hAA);  // no-op
    rom[7]  = mk(4'hF, 8'h07);  // unused opcode
    rom[8]  = mk(4'h1, 8'h00);
    rom[9]  = mk(4'h4, 8'h07);  // load from RAM
    rom[10] = mk(4'h5, 8'h07);  // add from RAM
    rom[11] = mk(4'h2, 8'h4C);  // wrap to zero
    rom[12] = mk(4'h7, 8'h03);  // unused opcode
    rom[13] = mk(4'h6, 8'h03);  // store zero
    for (int i = 14; i < 256; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      if (op >= 4'h4 && op <= 4'h6) rom[i] = mk(op, 8'($urandom_range(0, 15)));
      else                          rom[i] = mk(op, 8'($urandom_range(0, 255)));
    end

    repeat (3) @(negedge clk);
    check(wReg == 8'h00, "R3", "reset W", wReg, 0);
    check(zeroFlag == 1'b1, "R3", "reset zero flag", zeroFlag, 1);
    check(phase == 2'd0, "R1", "reset phase", phase, 0);
    check(progAddr == '0, "R2", "reset program address", progAddr, 0);
    check(ramWe == 1'b0, "R10", "no write in reset", ramWe, 0);

    rstN = 1'b1;
    mW = 8'h00; mZ = 1'b1; mPc = '0;
    for (int n = 0; n < 257; n++) runInstr();

    // Asynchronous reset in the middle of Q3
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(phase == 2'd2, "R12", "phase before reset", phase, 2);
    rstN = 1'b0;
    #0.5;
    check(wReg == 8'h00, "R12", "W after async reset", wReg, 0);
    check(zeroFlag == 1'b1, "R12", "zero flag after async reset", zeroFlag, 1);
    check(phase == 2'd0, "R12", "phase after async reset", phase, 0);
    check(progAddr == '0, "R12", "address after async reset", progAddr, 0);
    @(negedge clk);
    rstN = 1'b1;
    mW = 8'h00; mZ = 1'b1; mPc = '0;
    for (int n = 0; n < 14; n++) runInstr();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule